// File: doc/BRIEF.md
# Two-Cycle Synchronous Bus Initiator

This block lets a processor core run single read and write transfers on a shared synchronous system bus. The core hands over one command at a time (direction, address and, for a write, the data) through a valid/ready port. The block then raises a bus request and waits for the arbiter's grant. Only after the grant has been seen does it drive the bus. Every transfer takes exactly two bus cycles. In the first cycle the address, the strobes and any write data are driven. Read data is latched on the falling clock edge in the middle of the second cycle. At the edge that closes the second cycle, the request, the strobes and all output enables are dropped together.

All bus-side sampling (the grant and the returned read data) happens only on the falling edge of the clock. Everything facing the core, and every driven bus signal, changes only on the rising edge. When no transfer is granted, the address and data drivers are switched off through their output enables, so other initiators can use the same wires. In the cycle after a transfer ends, the core sees a one-cycle completion pulse and, for a read, the captured word.

Top module: `tcb_initiator`

## Requirements
- R1: After a synchronous reset, `cmd_ready` is high. `bus_req`, `bus_rd`, `bus_ma`, `bus_addr_oe`, `bus_data_oe` and `done` are all low. The ready signal is high only while the block is idle and holds no bus request.
- R2: A command accepted on a rising edge (`cmd_valid` and `cmd_ready` both high) raises `bus_req` at that edge. The block drives no strobe and no output enable until the grant has been sampled high on a falling edge.
- R3: The first transfer cycle begins at the first rising edge after the grant is sampled high. At that edge, `bus_addr` carries the command address, `bus_addr_oe` and `bus_ma` go high, and `bus_rd` is 1 for a read and 0 for a write. `bus_rd` is never high without `bus_ma`.
- R4: For a write, `bus_data_oe` is high and `bus_dout` equals the write data from the start of the first cycle to the end of the second. Address and data stay stable across both cycles. For a read, `bus_data_oe` stays low.
- R5: `bus_ma` stays high for exactly two clock cycles per transfer.
- R6: Read data is taken from `bus_din` only at the falling edge inside the second cycle. Values present at the falling edge of the first cycle, or after the transfer, do not reach `rdata`.
- R7: At the rising edge that ends the second cycle, `bus_req`, `bus_rd`, `bus_ma`, `bus_addr_oe` and `bus_data_oe` all return to low together.
- R8: `done` is high for exactly the one cycle after the second transfer cycle, with `rdata` valid for reads. `cmd_ready` is high again in the cycle that follows.
- R9: `cmd_valid` raised while a transfer is in progress has no effect: the bus address does not change, and no new request follows the transfer.
- R10: A reset asserted during a transfer returns the block to idle at the next rising edge, with the request, strobes and enables low and no `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus sampling on falling edge, all else on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Core offers a command |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Target address |
| cmd_wdata | input | DW | Write data |
| cmd_ready | output | 1 | Block idle and able to accept a command |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Read result, valid with `done` for reads |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_addr | output | AW | Address lines |
| bus_addr_oe | output | 1 | Address driver enable |
| bus_dout | output | DW | Data lines driven for writes |
| bus_data_oe | output | 1 | Data driver enable |
| bus_din | input | DW | Data lines sampled for reads |
| bus_rd | output | 1 | Read strobe |
| bus_ma | output | 1 | Memory-active strobe |

## Verification
The request is due at the rising edge that accepts a command. The first transfer cycle starts one rising edge after the falling edge that sees the grant. The strobes drop, and `done` rises, two rising edges after the first cycle starts, and `cmd_ready` returns one edge later. The bench drives every input 1 ns after a rising edge and reads every output 2 ns after it, before the falling edge, and it steps through these edges one at a time. To show that only the mid-second-cycle falling edge counts, the modelled memory puts a wrong word on the data lines during the first cycle and after the transfer. A scoreboard queue then matches each `done` against the result expected for the command that caused it.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_T1   = 3'd2,
    ST_T2   = 3'd3,
    ST_DONE = 3'd4
  } tcb_state_e;

endpackage

// File: rtl/tcb_cmd_hold.sv
module tcb_cmd_hold #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);

  // single-entry holding register for the accepted command
  always_ff @(posedge clk) begin
    if (rst) begin
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      we_o    <= we_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

endmodule

// File: rtl/tcb_seq.sv
module tcb_seq
  import tcb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_valid_i,
  input  logic gnt_q_i,
  output logic ready_o,
  output logic accept_o,
  output logic bus_req_o,
  output logic done_o,
  output logic go_t1_o,
  output logic in_t2_o,
  output logic end_t2_o
);

  tcb_state_e state_q;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = cmd_valid_i && ready_o;
  assign go_t1_o  = (state_q == ST_REQ) && gnt_q_i;
  assign in_t2_o  = (state_q == ST_T2);
  assign end_t2_o = (state_q == ST_T2);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bus_req_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          state_q   <= ST_REQ;
          bus_req_o <= 1'b1;
        end
        ST_REQ:  if (gnt_q_i) state_q <= ST_T1;
        ST_T1:   state_q <= ST_T2;
        ST_T2: begin
          state_q   <= ST_DONE;
          bus_req_o <= 1'b0;
          done_o    <= 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: idle never coexists with an outstanding request
  p_ready_no_req_r1: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> !bus_req_o);

  // R8: completion is a single-cycle pulse, followed by readiness
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!done_o && ready_o));

endmodule

// File: rtl/tcb_bus_if.sv
module tcb_bus_if #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_gnt_i,
  input  logic [DW-1:0] bus_din_i,
  input  logic          bus_req_i,
  input  logic          go_t1_i,
  input  logic          in_t2_i,
  input  logic          end_t2_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          gnt_q_o,
  output logic [DW-1:0] rd_cap_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          addr_oe_o,
  output logic [DW-1:0] bus_dout_o,
  output logic          data_oe_o,
  output logic          rd_o,
  output logic          ma_o
);

  // falling-edge interface registers: grant and read data
  always_ff @(negedge clk) begin
    if (rst) begin
      gnt_q_o  <= 1'b0;
      rd_cap_o <= '0;
    end else begin
      gnt_q_o <= bus_gnt_i;
      if (in_t2_i && rd_o) rd_cap_o <= bus_din_i;
    end
  end

  // rising-edge drivers for the bus
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr_o <= '0;
      addr_oe_o  <= 1'b0;
      bus_dout_o <= '0;
      data_oe_o  <= 1'b0;
      rd_o       <= 1'b0;
      ma_o       <= 1'b0;
    end else if (go_t1_i) begin
      bus_addr_o <= addr_i;
      addr_oe_o  <= 1'b1;
      bus_dout_o <= we_i ? wdata_i : '0;
      data_oe_o  <= we_i;
      rd_o       <= !we_i;
      ma_o       <= 1'b1;
    end else if (end_t2_i) begin
      bus_addr_o <= '0;
      addr_oe_o  <= 1'b0;
      bus_dout_o <= '0;
      data_oe_o  <= 1'b0;
      rd_o       <= 1'b0;
      ma_o       <= 1'b0;
    end
  end

  // R2: nothing driven without request and sampled grant
  p_drive_needs_grant_r2: assert property (@(posedge clk) disable iff (rst)
    (ma_o || addr_oe_o || data_oe_o) |-> (bus_req_i && gnt_q_o));

  // R3: read strobe only inside an active transfer
  p_rd_inside_ma_r3: assert property (@(posedge clk) disable iff (rst)
    rd_o |-> ma_o);

  // R4: address and write data hold across both cycles
  p_lines_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (ma_o && $past(ma_o)) |-> ($stable(bus_addr_o) && $stable(bus_dout_o) && $stable(data_oe_o)));

  // R5: strobe lasts two cycles, no more, no less
  p_ma_min_two_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ma_o) |=> ma_o);
  p_ma_max_two_r5: assert property (@(posedge clk) disable iff (rst)
    (ma_o && $past(ma_o)) |=> !ma_o);

  // R7: everything released together
  p_release_all_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(ma_o) |-> (!rd_o && !addr_oe_o && !data_oe_o && !bus_req_i));

endmodule

// File: rtl/tcb_initiator.sv
module tcb_initiator #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic          bus_addr_oe,
  output logic [DW-1:0] bus_dout,
  output logic          bus_data_oe,
  input  logic [DW-1:0] bus_din,
  output logic          bus_rd,
  output logic          bus_ma
);

  logic          accept, gnt_q, go_t1, in_t2, end_t2;
  logic          h_we;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_wdata;
  logic [DW-1:0] rd_cap;

  tcb_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid_i(cmd_valid),
    .gnt_q_i    (gnt_q),
    .ready_o    (cmd_ready),
    .accept_o   (accept),
    .bus_req_o  (bus_req),
    .done_o     (done),
    .go_t1_o    (go_t1),
    .in_t2_o    (in_t2),
    .end_t2_o   (end_t2)
  );

  tcb_cmd_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .we_i   (cmd_we),
    .addr_i (cmd_addr),
    .wdata_i(cmd_wdata),
    .we_o   (h_we),
    .addr_o (h_addr),
    .wdata_o(h_wdata)
  );

  tcb_bus_if #(.AW(AW), .DW(DW)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .bus_gnt_i (bus_gnt),
    .bus_din_i (bus_din),
    .bus_req_i (bus_req),
    .go_t1_i   (go_t1),
    .in_t2_i   (in_t2),
    .end_t2_i  (end_t2),
    .we_i      (h_we),
    .addr_i    (h_addr),
    .wdata_i   (h_wdata),
    .gnt_q_o   (gnt_q),
    .rd_cap_o  (rd_cap),
    .bus_addr_o(bus_addr),
    .addr_oe_o (bus_addr_oe),
    .bus_dout_o(bus_dout),
    .data_oe_o (bus_data_oe),
    .rd_o      (bus_rd),
    .ma_o      (bus_ma)
  );

  // core-side result register, loaded as the second cycle closes
  always_ff @(posedge clk) begin
    if (rst)                rdata <= '0;
    else if (end_t2 && !h_we) rdata <= rd_cap;
  end

  // R8: a completion always directly follows the end of a strobe
  p_done_after_ma_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(bus_ma) && !bus_ma));

endmodule

// File: tb/tcb_initiator_tb_top.sv
`timescale 1ns/100ps
module tcb_initiator_tb_top;

  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_we = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          cmd_ready, done;
  logic [DW-1:0] rdata;
  logic          bus_req;
  logic          bus_gnt = 1'b0;
  logic [AW-1:0] bus_addr;
  logic          bus_addr_oe;
  logic [DW-1:0] bus_dout;
  logic          bus_data_oe;
  logic [DW-1:0] bus_din = '0;
  logic          bus_rd, bus_ma;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  typedef struct { bit we; logic [DW-1:0] data; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  tcb_initiator #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_ready(cmd_ready), .done(done), .rdata(rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe),
    .bus_dout(bus_dout), .bus_data_oe(bus_data_oe),
    .bus_din(bus_din), .bus_rd(bus_rd), .bus_ma(bus_ma)
  );

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return (a * 16'd3) ^ 16'h5A5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk); #2;
      if (done) begin
        if (sb_q.size() == 0) chk(1'b0, "R8 unexpected done", 32'(done), 32'd0);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          if (!e.we) chk(rdata == e.data, "R6 read data", 32'(rdata), 32'(e.data));
          else       chk(1'b1, "R8 write done", 32'd1, 32'd1);
        end
      end
    end
  end

  task automatic run_txn(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input int gdly, input bit poke);
    exp_t e;
    e.we = we; e.data = mem_val(a);
    sb_q.push_back(e);
    @(posedge clk); #1;
    chk(cmd_ready, "R1 ready before issue", 32'(cmd_ready), 32'd1);
    cmd_valid = 1'b1; cmd_we = we; cmd_addr = a; cmd_wdata = wd;
    @(posedge clk); #1;
    cmd_valid = 1'b0; #1;
    chk(bus_req, "R2 request raised", 32'(bus_req), 32'd1);
    chk(!bus_ma && !bus_addr_oe && !bus_data_oe, "R2 no drive before grant",
        {bus_ma, bus_addr_oe, bus_data_oe}, 32'd0);
    for (int i = 0; i < gdly; i++) begin
      @(posedge clk); #2;
      chk(bus_req && !bus_ma && !bus_addr_oe && !bus_data_oe, "R2 waiting for grant",
          {bus_req, bus_ma, bus_addr_oe, bus_data_oe}, 32'h8);
    end
    @(posedge clk); #1;
    bus_gnt = 1'b1; #1;
    chk(!bus_ma, "R2 grant not yet sampled", 32'(bus_ma), 32'd0);
    // T1
    @(posedge clk); #1;
    bus_din = ~mem_val(a);
    if (poke) begin cmd_valid = 1'b1; cmd_we = !we; cmd_addr = ~a; end
    #1;
    chk(bus_ma && bus_addr_oe && bus_addr == a, "R3 T1 address and strobe",
        {bus_ma, bus_addr_oe, bus_addr}, {2'b11, a});
    chk(bus_rd == !we, "R3 read strobe level", 32'(bus_rd), 32'(!we));
    chk(bus_data_oe == we, "R4 data enable in T1", 32'(bus_data_oe), 32'(we));
    if (we) chk(bus_dout == wd, "R4 write data in T1", 32'(bus_dout), 32'(wd));
    // T2
    @(posedge clk); #1;
    bus_din = mem_val(a); #1;
    chk(bus_ma && bus_rd == !we, "R5 strobe held in T2", {bus_ma, bus_rd}, {1'b1, !we});
    chk(bus_addr == a, "R9 address unchanged", 32'(bus_addr), 32'(a));
    if (we) chk(bus_dout == wd && bus_data_oe, "R4 write data in T2", 32'(bus_dout), 32'(wd));
    // cycle after T2
    @(posedge clk); #1;
    bus_din = 16'hDEAD; bus_gnt = 1'b0; cmd_valid = 1'b0; #1;
    chk(!bus_ma && !bus_rd && !bus_addr_oe && !bus_data_oe && !bus_req, "R7 released",
        {bus_ma, bus_rd, bus_addr_oe, bus_data_oe, bus_req}, 32'd0);
    chk(done, "R8 done pulse", 32'(done), 32'd1);
    chk(!cmd_ready, "R8 not ready during done", 32'(cmd_ready), 32'd0);
    @(posedge clk); #2;
    chk(!done && cmd_ready, "R8 ready after done", {done, cmd_ready}, 32'd1);
    if (poke) begin
      for (int i = 0; i < 2; i++) begin
        @(posedge clk); #2;
        chk(!bus_req && cmd_ready, "R9 busy command ignored", {bus_req, cmd_ready}, 32'd1);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0; #1;
    chk(cmd_ready && !bus_req && !bus_rd && !bus_ma && !bus_addr_oe && !bus_data_oe && !done,
        "R1 reset state",
        {cmd_ready, bus_req, bus_rd, bus_ma, bus_addr_oe, bus_data_oe, done}, 32'h40);

    run_txn(1'b0, 16'h0010, 16'h0000, 0, 1'b0);
    run_txn(1'b1, 16'h1234, 16'hBEEF, 2, 1'b0);
    run_txn(1'b0, 16'hFFFF, 16'h0000, 3, 1'b1);
    run_txn(1'b1, 16'h0000, 16'hFFFF, 1, 1'b1);
    run_txn(1'b0, 16'h8001, 16'h0000, 5, 1'b0);

    // R10: reset in the middle of a transfer
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_we = 1'b0; cmd_addr = 16'h0777;
    @(posedge clk); #1;
    cmd_valid = 1'b0; bus_gnt = 1'b1;
    @(posedge clk); #2;
    @(posedge clk); #2;
    chk(bus_ma, "R10 transfer under way", 32'(bus_ma), 32'd1);
    #1 rst = 1'b1;
    @(posedge clk); #2;
    chk(!bus_ma && !bus_rd && !bus_req && !bus_addr_oe && !bus_data_oe && !done && cmd_ready,
        "R10 reset mid-transfer",
        {bus_ma, bus_rd, bus_req, bus_addr_oe, bus_data_oe, done, cmd_ready}, 32'h1);
    #1 rst = 1'b0; bus_gnt = 1'b0;
    repeat (2) begin
      @(posedge clk); #2;
      chk(!done && !bus_req, "R10 no completion after reset", {done, bus_req}, 32'd0);
    end

    run_txn(1'b0, 16'h0777, 16'h0000, 0, 1'b0);
    repeat (2) @(posedge clk);
    chk(sb_q.size() == 0, "R8 all completions seen", 32'(sb_q.size()), 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule